// File: doc/BRIEF.md
# Byte-wide configuration loader

This block runs on the host side of a programmable device that is loaded through a byte-wide asynchronous peripheral port. A start pulse latches the load parameters. After that the block takes image bytes from a valid/ready stream and writes each byte to the device by driving an active-low write strobe and an 8-bit data bus. Before each write it waits until the device shows ready. It counts bytes against its own latched length. The count never comes from the length field inside the image, because that field can be two less than the true bit total.

While a load runs, the block watches the device's active-low error/init line and its ready/busy line. When the last image byte has been written, it waits for the device's DONE line. It then makes one extra write with don't-care data (0xFF), because the device keeps its I/O pins tri-stated until that write arrives. Only after this extra write does the block report success. A load can also end in one of three failures: an init error, a ready timeout or a DONE timeout.

The three device inputs pass through a synchronizer of `SYNC_STAGES` flops before the control logic uses them. The image length must be at least 1.

Top module: `byte_cfg_loader`

## Requirements
- R1: After reset, `devWrN` is high, `inReady` is low, and `loadBusy`, `loadOk` and `loadFail` are all low.
- R2: A write strobe starts only after the synchronized `devRdy` was high in the cycle before. No write begins while the device shows busy.
- R3: `devWrN` stays low for exactly max(2, `strobeCycles`) clock cycles per write. `devData` holds one value through the whole low period and through the first cycle after `devWrN` rises.
- R4: A load writes exactly `imageLen` image bytes, in stream order. `imageLen`, `strobeCycles`, `busyLimit` and `doneLimit` are sampled on the accepted start. Later changes to them have no effect on a load in progress.
- R5: After the last image byte, once the synchronized DONE and ready are both high, exactly one extra write of 0xFF is made. `loadOk` rises only after that write completes.
- R6: `failCode` encodings: 0 = none, 1 = init error, 2 = ready timeout, 3 = DONE timeout. `failCode` is meaningful while `loadFail` is high.
- R7: If the synchronized `devInitN` is low during a load, the load ends in FAIL with `failCode` 1. No further bytes are taken or written.
- R8: If the synchronized `devRdy` stays low for `busyLimit` cycles while the block waits to write an image byte, the load ends in FAIL with `failCode` 2.
- R9: If DONE and ready are not both seen within `doneLimit` cycles after the last image byte, the load ends in FAIL with `failCode` 3. No extra write is made.
- R10: `start` is accepted only when the block is idle, in OK or in FAIL. A start pulse during a load has no effect. A start from FAIL begins a new load.
- R11: `inReady` is high only while the block waits for an image byte and the device shows ready. Bytes offered beyond `imageLen` are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for a load |
| imageLen | input | LEN_W | Number of image bytes to write |
| strobeCycles | input | STB_W | Write strobe low time in cycles (values below 2 act as 2) |
| busyLimit | input | TMO_W | Maximum number of busy cycles before a ready timeout |
| doneLimit | input | TMO_W | Maximum number of cycles to wait for DONE after the last byte |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inReady | output | 1 | Stream byte taken when high together with `inValid` |
| devWrN | output | 1 | Active-low write strobe to the device |
| devData | output | 8 | Data bus to the device |
| devRdy | input | 1 | Device ready (high) or busy (low), asynchronous |
| devInitN | input | 1 | Device error/init line, active low, asynchronous |
| devDone | input | 1 | Device DONE line, asynchronous |
| loadBusy | output | 1 | High while a load is in progress |
| loadOk | output | 1 | Load completed, extra write made |
| loadFail | output | 1 | Load ended in a failure |
| failCode | output | 2 | Failure reason, see R6 |

## Verification
The bench targets the write made after DONE. It checks that this write happens exactly once and only after DONE. A design that reports success straight at DONE shows one write too few. A design that loops on DONE shows a second post-DONE write. The bench also drops the error/init line between two writes, where a design that polls it only at strobe time would take another byte. It holds busy past the limit, which a design lacking a timeout would never leave. Finally, it changes the length and pulses start in the middle of a load. A design that reads its live inputs, or that restarts, writes the wrong number of bytes.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RDY,
    ST_STROBE,
    ST_HOLD,
    ST_WAIT_DONE,
    ST_DUMMY_WRITE,
    ST_OK,
    ST_FAIL
  } ldState_t;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_INIT = 2'd1,
    FC_BUSY = 2'd2,
    FC_DONE = 2'd3
  } failCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;     // latch parameters, clear byte count
    logic acceptByte;  // take stream byte into data register
    logic loadDummy;   // load the don't-care byte
    logic clrWait;     // clear wait timer
    logic incWait;     // advance wait timer
    logic selDone;     // compare wait timer against DONE limit
    logic clrStb;      // restart strobe width counter
    logic strobeLow;   // write strobe active
  } dpCtl_t;

  localparam logic [7:0] DUMMY_BYTE = 8'hFF;

endpackage

// File: rtl/cfg_load_dp.sv
module cfg_load_dp
  import cfg_load_pkg::*;
#(
  parameter int LEN_W       = 20,
  parameter int STB_W       = 4,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [LEN_W-1:0] imageLen,
  input  logic [STB_W-1:0] strobeCycles,
  input  logic [TMO_W-1:0] busyLimit,
  input  logic [TMO_W-1:0] doneLimit,
  input  logic [7:0]       inData,
  input  logic             devRdy,
  input  logic             devInitN,
  input  logic             devDone,
  output logic             devWrN,
  output logic [7:0]       devData,
  output logic             rdyS,
  output logic             initNS,
  output logic             doneS,
  output logic             lastByte,
  output logic             stbDone,
  output logic             waitHit
);

  localparam int SYNC_W = 3 * SYNC_STAGES;
  localparam logic [2:0] SYNC_RST = 3'b010;  // {done, initN, rdy}
  localparam logic [STB_W-1:0] MIN_STB = STB_W'(2);

  logic [2:0]        rawIn;
  logic [SYNC_W-1:0] syncPipe;

  assign rawIn = {devDone, devInitN, devRdy};

  generate
    if (SYNC_STAGES == 1) begin : g_syncOne
      always_ff @(posedge clk) begin
        if (!rstN) syncPipe <= SYNC_RST;
        else       syncPipe <= rawIn;
      end
    end else begin : g_syncChain
      always_ff @(posedge clk) begin
        if (!rstN) syncPipe <= {SYNC_STAGES{SYNC_RST}};
        else       syncPipe <= {syncPipe[SYNC_W-4:0], rawIn};
      end
    end
  endgenerate

  assign {doneS, initNS, rdyS} = syncPipe[SYNC_W-1 -: 3];

  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] byteCnt;
  logic [STB_W-1:0] stbReg;
  logic [STB_W-1:0] stbCnt;
  logic [TMO_W-1:0] busyLimReg;
  logic [TMO_W-1:0] doneLimReg;
  logic [TMO_W-1:0] waitCnt;
  logic [7:0]       dataReg;
  logic [STB_W-1:0] stbEff;

  assign stbEff = (strobeCycles < MIN_STB) ? MIN_STB : strobeCycles;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg     <= '0;
      stbReg     <= MIN_STB;
      busyLimReg <= '0;
      doneLimReg <= '0;
    end else if (ctl.loadCfg) begin
      lenReg     <= imageLen;
      stbReg     <= stbEff;
      busyLimReg <= busyLimit;
      doneLimReg <= doneLimit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      dataReg <= '0;
    end else if (ctl.loadCfg) begin
      byteCnt <= '0;
    end else if (ctl.acceptByte) begin
      byteCnt <= byteCnt + 1'b1;
      dataReg <= inData;
    end else if (ctl.loadDummy) begin
      dataReg <= DUMMY_BYTE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         stbCnt <= STB_W'(1);
    else if (ctl.clrStb)               stbCnt <= STB_W'(1);
    else if (ctl.strobeLow && !stbDone) stbCnt <= stbCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            waitCnt <= '0;
    else if (ctl.clrWait)                 waitCnt <= '0;
    else if (ctl.incWait && waitCnt != '1) waitCnt <= waitCnt + 1'b1;
  end

  assign lastByte = (byteCnt == lenReg);
  assign stbDone  = (stbCnt >= stbReg);
  assign waitHit  = (waitCnt >= (ctl.selDone ? doneLimReg : busyLimReg));
  assign devWrN   = ~ctl.strobeLow;
  assign devData  = dataReg;

  // R3: data bus frozen while strobing and one cycle after
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.strobeLow) |-> $stable(dataReg));

  // R4: never more bytes than the latched length
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= lenReg);

endmodule

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
  import cfg_load_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       inValid,
  input  logic       rdyS,
  input  logic       initNS,
  input  logic       doneS,
  input  logic       lastByte,
  input  logic       stbDone,
  input  logic       waitHit,
  output dpCtl_t     ctl,
  output logic       inReady,
  output logic       loadBusy,
  output logic       loadOk,
  output logic       loadFail,
  output logic [1:0] failCode
);

  ldState_t  state, nxt;
  failCode_t failReg, failNxt;
  logic      dummyPhase;
  logic      active;

  assign active = (state == ST_WAIT_RDY) || (state == ST_STROBE) || (state == ST_HOLD) ||
                  (state == ST_WAIT_DONE) || (state == ST_DUMMY_WRITE);
  assign inReady = (state == ST_WAIT_RDY) && rdyS && initNS;

  always_comb begin
    ctl     = '0;
    nxt     = state;
    failNxt = failReg;
    unique case (state)
      ST_IDLE, ST_OK, ST_FAIL: begin
        if (start) begin
          ctl.loadCfg = 1'b1;
          ctl.clrWait = 1'b1;
          failNxt     = FC_NONE;
          nxt         = ST_WAIT_RDY;
        end
      end
      ST_WAIT_RDY: begin
        if (rdyS) begin
          ctl.clrWait = 1'b1;
          if (inValid && inReady) begin
            ctl.acceptByte = 1'b1;
            ctl.clrStb     = 1'b1;
            nxt            = ST_STROBE;
          end
        end else begin
          ctl.incWait = 1'b1;
          if (waitHit) begin
            nxt     = ST_FAIL;
            failNxt = FC_BUSY;
          end
        end
      end
      ST_STROBE, ST_DUMMY_WRITE: begin
        ctl.strobeLow = 1'b1;
        if (stbDone) nxt = ST_HOLD;
      end
      ST_HOLD: begin
        ctl.clrWait = 1'b1;
        if (dummyPhase)    nxt = ST_OK;
        else if (lastByte) nxt = ST_WAIT_DONE;
        else               nxt = ST_WAIT_RDY;
      end
      ST_WAIT_DONE: begin
        ctl.selDone = 1'b1;
        if (doneS && rdyS) begin
          ctl.loadDummy = 1'b1;
          ctl.clrStb    = 1'b1;
          nxt           = ST_DUMMY_WRITE;
        end else begin
          ctl.incWait = 1'b1;
          if (waitHit) begin
            nxt     = ST_FAIL;
            failNxt = FC_DONE;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
    // init error overrides everything during a load
    if (active && !initNS) begin
      ctl.acceptByte = 1'b0;
      ctl.loadDummy  = 1'b0;
      nxt            = ST_FAIL;
      failNxt        = FC_INIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      failReg    <= FC_NONE;
      dummyPhase <= 1'b0;
    end else begin
      state   <= nxt;
      failReg <= failNxt;
      if (ctl.loadDummy)    dummyPhase <= 1'b1;
      else if (ctl.loadCfg) dummyPhase <= 1'b0;
    end
  end

  assign loadBusy = active;
  assign loadOk   = (state == ST_OK);
  assign loadFail = (state == ST_FAIL);
  assign failCode = failReg;

  // R3: a strobe lasts at least two cycles
  p_strobe_min_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.strobeLow) |=> ctl.strobeLow);

  // R2: a write starts only after ready was seen
  p_write_needs_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.strobeLow) |-> $past(rdyS));

  // R7: init low during a load ends in FAIL with the init code
  p_init_aborts_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadBusy && !initNS) |=> (loadFail && failCode == FC_INIT));

  // R5: success only right after the extra write's hold cycle
  p_ok_after_dummy_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadOk) |-> $past(state == ST_HOLD && dummyPhase));

  // R10: FAIL is left only through start
  p_fail_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (loadFail && !start) |=> loadFail);

endmodule

// File: rtl/byte_cfg_loader.sv
module byte_cfg_loader
  import cfg_load_pkg::*;
#(
  parameter int LEN_W       = 20,
  parameter int STB_W       = 4,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] imageLen,
  input  logic [STB_W-1:0] strobeCycles,
  input  logic [TMO_W-1:0] busyLimit,
  input  logic [TMO_W-1:0] doneLimit,
  input  logic             inValid,
  input  logic [7:0]       inData,
  output logic             inReady,
  output logic             devWrN,
  output logic [7:0]       devData,
  input  logic             devRdy,
  input  logic             devInitN,
  input  logic             devDone,
  output logic             loadBusy,
  output logic             loadOk,
  output logic             loadFail,
  output logic [1:0]       failCode
);

  dpCtl_t ctl;
  logic   rdyS, initNS, doneS, lastByte, stbDone, waitHit;

  cfg_load_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .rdyS     (rdyS),
    .initNS   (initNS),
    .doneS    (doneS),
    .lastByte (lastByte),
    .stbDone  (stbDone),
    .waitHit  (waitHit),
    .ctl      (ctl),
    .inReady  (inReady),
    .loadBusy (loadBusy),
    .loadOk   (loadOk),
    .loadFail (loadFail),
    .failCode (failCode)
  );

  cfg_load_dp #(
    .LEN_W       (LEN_W),
    .STB_W       (STB_W),
    .TMO_W       (TMO_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .imageLen     (imageLen),
    .strobeCycles (strobeCycles),
    .busyLimit    (busyLimit),
    .doneLimit    (doneLimit),
    .inData       (inData),
    .devRdy       (devRdy),
    .devInitN     (devInitN),
    .devDone      (devDone),
    .devWrN       (devWrN),
    .devData      (devData),
    .rdyS         (rdyS),
    .initNS       (initNS),
    .doneS        (doneS),
    .lastByte     (lastByte),
    .stbDone      (stbDone),
    .waitHit      (waitHit)
  );

endmodule

// File: tb/byte_cfg_loader_bench.sv
`timescale 1ns/1ps
module byte_cfg_loader_bench;

  localparam int LEN_W = 20;
  localparam int STB_W = 4;
  localparam int TMO_W = 16;
  localparam int WATCHDOG_NS = 600000;

  // columns: len, strobe, busyDelay, doneOn, errAfter, busyLimit, expCode
  localparam int VEC_N = 7;
  localparam int VEC [VEC_N][7] = '{
    '{5,  2, 3,   1, 0, 100, 0},
    '{12, 5, 0,   1, 0, 100, 0},
    '{3,  0, 7,   1, 0, 100, 0},
    '{4,  3, 2,   0, 0, 100, 3},
    '{8,  2, 1,   1, 3, 100, 1},
    '{6,  2, 400, 1, 0, 40,  2},
    '{1,  15, 1,  1, 0, 100, 0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] imageLen = '0;
  logic [STB_W-1:0] strobeCycles = '0;
  logic [TMO_W-1:0] busyLimit = '0;
  logic [TMO_W-1:0] doneLimit = '0;
  logic inValid, inReady, devWrN, devRdy, devInitN, devDone;
  logic [7:0] inData, devData;
  logic loadBusy, loadOk, loadFail;
  logic [1:0] failCode;

  int checks = 0;
  int fails = 0;

  // stream and device model state
  logic feedOn = 1'b0;
  int feedLen = 0;
  logic [7:0] feedBase = 8'h00;
  int sentIdx;
  int cfgBusy = 1, cfgDoneAfter = 0, cfgDoneDelay = 10, cfgErrAfter = 0;
  int busyCnt, doneCnt, wrCount, postDone, rdyViol, holdBad, minLow, maxLow, lowRun;
  logic [7:0] dataXor, wrData, lastDummy;
  logic prevWrN;

  always #2 clk = ~clk;

  assign inValid = feedOn && (sentIdx < feedLen);
  assign inData  = feedBase + 8'(sentIdx);

  byte_cfg_loader #(.LEN_W(LEN_W), .STB_W(STB_W), .TMO_W(TMO_W), .SYNC_STAGES(2)) u_byte_cfg_loader (
    .clk(clk), .rstN(rstN), .start(start), .imageLen(imageLen), .strobeCycles(strobeCycles),
    .busyLimit(busyLimit), .doneLimit(doneLimit), .inValid(inValid), .inData(inData),
    .inReady(inReady), .devWrN(devWrN), .devData(devData), .devRdy(devRdy),
    .devInitN(devInitN), .devDone(devDone), .loadBusy(loadBusy), .loadOk(loadOk),
    .loadFail(loadFail), .failCode(failCode)
  );

  // device model and monitor
  always @(posedge clk) begin
    if (!rstN) begin
      devRdy <= 1'b1; devInitN <= 1'b1; devDone <= 1'b0; sentIdx <= 0;
      busyCnt = 0; doneCnt = 0; wrCount = 0; postDone = 0; rdyViol = 0; holdBad = 0;
      minLow = 1000; maxLow = 0; lowRun = 0; prevWrN = 1'b1;
      dataXor = 8'h00; wrData = 8'h00; lastDummy = 8'h00;
    end else begin
      if (inValid && inReady) sentIdx <= sentIdx + 1;
      if (busyCnt > 0) begin
        busyCnt--;
        if (busyCnt == 0) devRdy <= 1'b1;
      end
      if (doneCnt > 0) begin
        doneCnt--;
        if (doneCnt == 0) devDone <= 1'b1;
      end
      if (!devWrN) begin
        if (prevWrN) begin
          if (!devRdy) rdyViol++;
          devRdy <= 1'b0; busyCnt = 0; lowRun = 0; wrData = devData;
        end
        lowRun++;
        if (devData != wrData) holdBad++;
      end else if (!prevWrN) begin
        if (devData != wrData) holdBad++;
        if (lowRun < minLow) minLow = lowRun;
        if (lowRun > maxLow) maxLow = lowRun;
        wrCount++;
        if (devDone) begin postDone++; lastDummy = devData; end
        else dataXor ^= devData;
        busyCnt = cfgBusy;
        if (cfgBusy == 0) devRdy <= 1'b1;
        if (wrCount == cfgDoneAfter) doneCnt = cfgDoneDelay;
        if (wrCount == cfgErrAfter) devInitN <= 1'b0;
      end
      prevWrN = devWrN;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; feedOn = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitEnd(input int maxCycles);
    for (int c = 0; c < maxCycles; c++) begin
      if (loadOk || loadFail) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  int actOut, expOut, nonDummy, effStb;
  logic [7:0] expXor;

  initial begin
    #(WATCHDOG_NS);
    checks++; fails++;
    $display("FAIL watchdog (R1..all): actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 devWrN in reset", int'(devWrN), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 devWrN idle", int'(devWrN), 1);
    chk("R1 inReady idle", int'(inReady), 0);
    chk("R1 status idle", int'({loadBusy, loadOk, loadFail}), 0);

    // vector table walk
    for (int v = 0; v < VEC_N; v++) begin
      doReset();
      cfgBusy = VEC[v][2];
      cfgDoneAfter = (VEC[v][3] != 0) ? VEC[v][0] : 0;
      cfgDoneDelay = 10;
      cfgErrAfter = VEC[v][4];
      imageLen = LEN_W'(VEC[v][0]);
      strobeCycles = STB_W'(VEC[v][1]);
      busyLimit = TMO_W'(VEC[v][5]);
      doneLimit = TMO_W'(60);
      feedBase = 8'(VEC[v][0] * 7 + 3);
      feedLen = VEC[v][0] + 3;
      feedOn = 1'b1;
      pulseStart();
      waitEnd(6000);
      actOut = loadOk ? 0 : (loadFail ? 10 + int'(failCode) : 99);
      expOut = (VEC[v][6] == 0) ? 0 : 10 + VEC[v][6];
      chk("R6 R7 R8 R9 outcome", actOut, expOut);
      case (VEC[v][6])
        1: nonDummy = VEC[v][4];
        2: nonDummy = 1;
        default: nonDummy = VEC[v][0];
      endcase
      expXor = 8'h00;
      for (int i = 0; i < nonDummy; i++) expXor ^= feedBase + 8'(i);
      chk("R4 R5 R9 write count", wrCount, nonDummy + ((VEC[v][6] == 0) ? 1 : 0));
      chk("R4 byte content", int'(dataXor), int'(expXor));
      chk("R11 bytes taken", sentIdx, nonDummy);
      chk("R5 R9 writes after DONE", postDone, (VEC[v][6] == 0) ? 1 : 0);
      if (VEC[v][6] == 0) chk("R5 extra byte value", int'(lastDummy), 255);
      effStb = (VEC[v][1] < 2) ? 2 : VEC[v][1];
      chk("R3 strobe min width", minLow, effStb);
      chk("R3 strobe max width", maxLow, effStb);
      chk("R3 data hold", holdBad, 0);
      chk("R2 write while busy", rdyViol, 0);
      chk("R11 inReady after end", int'(inReady), 0);
    end

    // R10, R4: start and length change during a load are ignored
    doReset();
    cfgBusy = 4; cfgDoneAfter = 6; cfgErrAfter = 0;
    imageLen = LEN_W'(6); strobeCycles = STB_W'(3);
    busyLimit = TMO_W'(100); doneLimit = TMO_W'(60);
    feedBase = 8'h40; feedLen = 9; feedOn = 1'b1;
    pulseStart();
    for (int c = 0; c < 500 && wrCount < 2; c++) @(negedge clk);
    chk("R10 busy during load", int'(loadBusy), 1);
    imageLen = LEN_W'(2); strobeCycles = STB_W'(9);
    pulseStart();
    waitEnd(6000);
    chk("R10 mid-load start ignored", int'(loadOk), 1);
    chk("R4 latched length used", wrCount, 7);
    chk("R4 latched length bytes taken", sentIdx, 6);
    chk("R4 latched strobe width", maxLow, 3);

    // R10: restart from FAIL
    doReset();
    cfgBusy = 300; cfgDoneAfter = 0; cfgErrAfter = 0;
    imageLen = LEN_W'(3); strobeCycles = STB_W'(2);
    busyLimit = TMO_W'(30); doneLimit = TMO_W'(60);
    feedBase = 8'h10; feedLen = 10; feedOn = 1'b1;
    pulseStart();
    waitEnd(2000);
    chk("R8 ready timeout code", loadFail ? int'(failCode) : 9, 2);
    repeat (320) @(negedge clk);
    chk("R10 FAIL held without start", int'(loadFail), 1);
    begin
      int wr0, sent0;
      wr0 = wrCount; sent0 = sentIdx;
      cfgBusy = 2; cfgDoneAfter = wr0 + 2;
      feedLen = sent0 + 2;
      imageLen = LEN_W'(2);
      pulseStart();
      waitEnd(6000);
      chk("R10 restart from FAIL", int'(loadOk), 1);
      chk("R5 restart write count", wrCount - wr0, 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule